// File: doc/BRIEF.md
# Layer-2 Address/VLAN Bucket Key Generator

This block turns a 48-bit station address and a 12-bit VLAN identifier into an 11-bit bucket index for a hashed layer-2 forwarding table. It places the address above the VLAN identifier to form a 64-bit seed whose top four bits are zero. It then cuts the seed into five 11-bit slices and one 9-bit top slice, and folds them together with XOR.

A mode input picks one of two folds. In the plain fold all six slices are combined unchanged. In the rotating fold three of the 11-bit slices are rotated left before they are combined. The mode normally comes from bit 0 of a layer-2 control register and stays fixed during operation. It is sampled together with each accepted request.

Requests arrive on a valid/ready input that never applies backpressure. The key leaves through a register one cycle after the request is accepted. Table storage, lookup and learning sit outside this block.

Top module: `l2_bucket_keygen`

## Requirements
- R1: `in_ready` is 1 in every cycle, including during reset.
- R2: While `rst` is high at a rising clock edge, `out_valid` is 0 after that edge. It stays 0 until the first request is accepted.
- R3: `out_valid` after a rising edge equals `in_valid` sampled at that edge, outside reset. The latency is exactly one cycle.
- R4: The seed is `{4'b0, in_mac, in_vid}`. It is cut into 11-bit slices S0..S4 at bit offsets 0, 11, 22, 33 and 44, and a 9-bit top slice T at bits 63..55.
- R5: With `in_mode_rot` = 0, `out_key` = S0^S1^S2^S3^S4^T, with T zero-extended into key bits 8..0.
- R6: With `in_mode_rot` = 1, S1 is rotated left by 6, S3 by 5 and S4 by 4, each within 11 bits. S0, S2 and T are used unrotated. All six terms are then XORed. For example, seed bit 11 alone gives key 0x040.
- R7: The top slice is never rotated. `in_mac` bit 43 alone gives key 0x001 and `in_mac` bit 47 alone gives key 0x010, in both modes.
- R8: When `in_valid` is 0 at an edge, `out_key` keeps its previous value, whatever the other inputs do.
- R9: `in_mode_rot` is sampled with each accepted request. Back-to-back requests in different modes each get their own algorithm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Always 1 |
| in_mac | input | 48 | Station address |
| in_vid | input | 12 | VLAN identifier |
| in_mode_rot | input | 1 | 0 = plain fold, 1 = rotating fold |
| out_valid | output | 1 | Key valid, one cycle after acceptance |
| out_key | output | 11 | Bucket index |

## Verification
The only state in the block is the output register pair. A wrong valid flag or a stale key therefore shows up at the ports in the very next cycle after the request that should have changed it.

A slice taken from the wrong offset, or rotated by the wrong amount, moves a single seed bit to the wrong key bit. The single-bit stimulus vectors expose that at once, one per slice and per mode. Random address/VLAN pairs in both modes, compared against an independent model, catch mistakes in how the terms are combined.

// File: rtl/l2_bucket_pkg.sv
package l2_bucket_pkg;
  localparam int SEED_W  = 64;
  localparam int KEY_W   = 11;
  localparam int NFULL   = SEED_W / KEY_W;       // full-width slices
  localparam int TOP_LSB = NFULL * KEY_W;        // first bit of narrow top slice
  localparam int TOP_W   = SEED_W - TOP_LSB;

  // left-rotation applied to each full slice in the rotating fold
  function automatic int rot_amount(input int idx);
    case (idx)
      1:       return 6;
      3:       return 5;
      4:       return 4;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/l2_bucket_seed.sv
module l2_bucket_seed #(
  parameter int MAC_W  = 48,
  parameter int VID_W  = 12,
  parameter int SEED_W = 64
) (
  input  logic [MAC_W-1:0]  mac,
  input  logic [VID_W-1:0]  vid,
  output logic [SEED_W-1:0] seed
);
  localparam int PAD_W = SEED_W - MAC_W - VID_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign seed = {{PAD_W{1'b0}}, mac, vid};
    end else begin : g_nopad
      assign seed = {mac, vid};
    end
  endgenerate
endmodule

// File: rtl/l2_bucket_fold.sv
module l2_bucket_fold
  import l2_bucket_pkg::*;
(
  input  logic [SEED_W-1:0] seed,
  input  logic              mode_rot,
  output logic [KEY_W-1:0]  key
);
  logic [KEY_W-1:0] term [NFULL];
  logic [KEY_W-1:0] top_term;

  genvar gi;
  generate
    for (gi = 0; gi < NFULL; gi++) begin : g_slice
      localparam int R = rot_amount(gi);
      logic [KEY_W-1:0] raw;
      assign raw = seed[gi*KEY_W +: KEY_W];
      if (R == 0) begin : g_plain
        assign term[gi] = raw;
      end else begin : g_rot
        logic [KEY_W-1:0] rotated;
        assign rotated  = {raw[KEY_W-R-1:0], raw[KEY_W-1:KEY_W-R]};
        assign term[gi] = mode_rot ? rotated : raw;
      end
    end
  endgenerate

  assign top_term = {{(KEY_W-TOP_W){1'b0}}, seed[SEED_W-1:TOP_LSB]};

  always_comb begin
    key = top_term;
    for (int i = 0; i < NFULL; i++) key = key ^ term[i];
  end
endmodule

// File: rtl/l2_bucket_keygen.sv
module l2_bucket_keygen
  import l2_bucket_pkg::*;
#(
  parameter int MAC_W = 48,
  parameter int VID_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MAC_W-1:0]  in_mac,
  input  logic [VID_W-1:0]  in_vid,
  input  logic              in_mode_rot,
  output logic              out_valid,
  output logic [KEY_W-1:0]  out_key
);
  logic [SEED_W-1:0] seed;
  logic [KEY_W-1:0]  key_c;

  l2_bucket_seed #(.MAC_W(MAC_W), .VID_W(VID_W), .SEED_W(SEED_W)) u_seed (
    .mac (in_mac),
    .vid (in_vid),
    .seed(seed)
  );

  l2_bucket_fold u_fold (
    .seed    (seed),
    .mode_rot(in_mode_rot),
    .key     (key_c)
  );

  assign in_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_key   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_key <= key_c;
    end
  end

  always_comb assert_ready_R1: assert (in_ready === 1'b1);

  assert_reset_R2: assert property (@(posedge clk) rst |=> !out_valid);

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_key));
endmodule

// File: tb/l2_bucket_keygen_tb.sv
module l2_bucket_keygen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_mac = '0;
  logic [11:0] in_vid = '0;
  logic        in_mode_rot = 1'b0;
  logic        out_valid;
  logic [10:0] out_key;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  l2_bucket_keygen u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mac(in_mac), .in_vid(in_vid), .in_mode_rot(in_mode_rot),
    .out_valid(out_valid), .out_key(out_key)
  );

  // {mac, vid, mode, expected key}
  localparam logic [71:0] VEC [12] = '{
    {48'h0,            12'h000, 1'b0, 11'h000},
    {48'h0,            12'h7FF, 1'b0, 11'h7FF},
    {48'h0,            12'h7FF, 1'b1, 11'h7FF},
    {48'h0,            12'h800, 1'b0, 11'h001},
    {48'h0,            12'h800, 1'b1, 11'h040},
    {48'h1,            12'h000, 1'b1, 11'h080},
    {48'h400,          12'h000, 1'b1, 11'h001},
    {48'h200000,       12'h000, 1'b0, 11'h001},
    {48'h200000,       12'h000, 1'b1, 11'h020},
    {48'h100000000,    12'h000, 1'b1, 11'h010},
    {48'h080000000000, 12'h000, 1'b1, 11'h001},
    {48'h800000000000, 12'h000, 1'b0, 11'h010}
  };

  function automatic logic [10:0] rotl(input logic [10:0] v, input int n);
    logic [21:0] d;
    d = {v, v} << n;
    return d[21:11];
  endfunction

  function automatic logic [10:0] ref_key(input logic [47:0] m,
                                          input logic [11:0] v, input logic md);
    logic [63:0] s;
    logic [10:0] a1, a3, a4;
    s  = {4'h0, m, v};
    a1 = s[21:11]; a3 = s[43:33]; a4 = s[54:44];
    if (md) begin
      a1 = rotl(a1, 6); a3 = rotl(a3, 5); a4 = rotl(a4, 4);
    end
    return s[10:0] ^ a1 ^ s[32:22] ^ a3 ^ a4 ^ {2'b00, s[63:55]};
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] m, input logic [11:0] v, input logic md);
    in_valid = 1'b1; in_mac = m; in_vid = v; in_mode_rot = md;
    @(posedge clk); @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [10:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset valid", {10'b0, out_valid}, 11'h000);
    check("R1 ready in reset", {10'b0, in_ready}, 11'h001);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle after reset", {10'b0, out_valid}, 11'h000);

    // R4 R5 R6 R7: table of single-bit and boundary vectors
    for (int i = 0; i < 12; i++) begin
      send(VEC[i][71:24], VEC[i][23:12], VEC[i][11]);
      check("R3 valid", {10'b0, out_valid}, 11'h001);
      check(VEC[i][11] ? "R6/R7 rot key" : "R5/R7 plain key", out_key, VEC[i][10:0]);
    end

    // R9: alternating modes back to back, same input
    send(48'h0, 12'h800, 1'b0);
    check("R9 mode0", out_key, 11'h001);
    send(48'h0, 12'h800, 1'b1);
    check("R9 mode1", out_key, 11'h040);

    // R8: idle cycles with changing inputs keep the key
    held = out_key;
    in_valid = 1'b0; in_mac = 48'hFFFF_FFFF_FFFF; in_mode_rot = 1'b0;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check("R3 no valid", {10'b0, out_valid}, 11'h000);
      check("R8 hold", out_key, held);
      in_vid = in_vid + 12'h123;
    end

    // R4 R5 R6: random pairs against model
    for (int i = 0; i < 400; i++) begin
      logic [47:0] m;
      logic [11:0] v;
      logic md;
      m  = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      v  = 12'($urandom);
      md = 1'($urandom);
      send(m, v, md);
      check(md ? "R6 random" : "R5 random", out_key, ref_key(m, v, md));
    end
    check("R1 ready", {10'b0, in_ready}, 11'h001);

    // R2: reset mid-stream clears valid
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 reset during traffic", {10'b0, out_valid}, 11'h000);
    rst = 1'b0; in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2 stays low", {10'b0, out_valid}, 11'h000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule